// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block generates one active-low interrupt for each side of a two-sided shared memory. It watches the enable, write strobe, output enable, address and arbiter hold input of both sides. Each side owns one mailbox word at the top of the address space. Side A owns the address one below the highest. Side B owns the highest address. When the opposite side writes a side's mailbox, that side's interrupt is raised. When the owning side reads its mailbox, its interrupt is lowered again.

The mailbox data lives in the ordinary memory array and is outside this block, as is the collision arbiter. The arbiter reaches the block only through one active-low hold input per side. While a side is held, every set or clear that its access would cause is discarded. Both flags are registered, and the interrupt outputs are always driven.

Top module: `mbx_irq_flags`

## Requirements
- R1: While `rst_n` is low at a clock edge, both `a_irq_n` and `b_irq_n` are high (deasserted) after that edge.
- R2: A side-B write (`b_en_n`=0, `b_wr_n`=0) to address all-ones minus one (0x3FFE with the default 14-bit address) drives `a_irq_n` low after the clock edge that samples it.
- R3: A side-A write (`a_en_n`=0, `a_wr_n`=0) to the all-ones address (0x3FFF by default) drives `b_irq_n` low after the sampling edge.
- R4: A side-A access to all-ones minus one with `a_en_n`=0 and `a_oe_n`=0 returns `a_irq_n` high after the sampling edge, whatever the level of `a_wr_n`.
- R5: A side-B access to the all-ones address with `b_en_n`=0 and `b_oe_n`=0 returns `b_irq_n` high after the sampling edge.
- R6: While the accessing side's hold input (`a_hold_n` or `b_hold_n`) is low, its set or clear action leaves the flag unchanged.
- R7: If the same flag receives a set and a clear in the same cycle, the flag ends up asserted (low).
- R8: Accesses to other addresses, accesses with the enable high, and enabled accesses with neither the write strobe nor the output enable low leave both flags unchanged.
- R9: With `ADDR_W`=13, the mailbox addresses are 0x1FFE (side A) and 0x1FFF (side B), and the 14-bit addresses 0x3FFE and 0x3FFF lose their meaning.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_en_n | input | 1 | Side A memory enable, active low |
| a_wr_n | input | 1 | Side A write strobe, active low |
| a_oe_n | input | 1 | Side A output enable, active low |
| a_addr | input | ADDR_W | Side A address |
| a_hold_n | input | 1 | Side A held by the arbiter, active low |
| b_en_n | input | 1 | Side B memory enable, active low |
| b_wr_n | input | 1 | Side B write strobe, active low |
| b_oe_n | input | 1 | Side B output enable, active low |
| b_addr | input | ADDR_W | Side B address |
| b_hold_n | input | 1 | Side B held by the arbiter, active low |
| a_irq_n | output | 1 | Interrupt to side A, active low |
| b_irq_n | output | 1 | Interrupt to side B, active low |

## Verification
A raise and a lower of the same flag can land in the same cycle. This happens when one side writes the other's mailbox while the owner reads it. The bench provokes this for both flags by driving both sides at once. A flag that was deasserted just before shows whether the set won, and the flag must come out low. A second instance with a 13-bit address runs in parallel, so the bench can see that the mailbox decode follows the address width and that a 14-bit mailbox pattern does not act on it.

// File: rtl/mbx_pkg.sv
// Package: shared types for the mailbox interrupt flags.
// Assumes: two sides only; control strobes are active low.
package mbx_pkg;

    // Which side of the shared memory a piece of logic serves
    typedef enum logic {
        SIDE_A = 1'b0,
        SIDE_B = 1'b1
    } side_e;

    // Per-side access controls as seen at the memory edge
    typedef struct packed {
        logic en_n;
        logic wr_n;
        logic oe_n;
        logic hold_n;
    } side_ctl_t;

endpackage

// File: rtl/mbx_decode.sv
// Module: mbx_decode
// Decodes one side's access into two requests: raise the peer's flag
// (a write to the peer's mailbox) and lower this side's own flag (an
// output-enabled access to its own mailbox). A low hold input kills both.
// Assumes: side A owns all-ones minus one, side B owns all-ones.
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int    ADDR_W = 14,
    parameter side_e SIDE   = SIDE_A
) (
    input  side_ctl_t          ctl,
    input  logic [ADDR_W-1:0]  addr,
    output logic               set_peer,
    output logic               clr_own
);

    localparam logic [ADDR_W-1:0] TOP_ADDR  = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] BOX_A     = TOP_ADDR - 1'b1;
    localparam logic [ADDR_W-1:0] BOX_B     = TOP_ADDR;
    localparam logic [ADDR_W-1:0] OWN_BOX   = (SIDE == SIDE_A) ? BOX_A : BOX_B;
    localparam logic [ADDR_W-1:0] PEER_BOX  = (SIDE == SIDE_A) ? BOX_B : BOX_A;

    logic live;

    // Request generation: a selected, unheld access to one of the boxes
    always_comb begin
        live     = !ctl.en_n && ctl.hold_n;
        set_peer = live && !ctl.wr_n && (addr == PEER_BOX);
        clr_own  = live && !ctl.oe_n && (addr == OWN_BOX);
    end

endmodule

// File: rtl/mbx_flag.sv
// Module: mbx_flag
// One interrupt flag. A set request drives the output low, a clear
// request drives it high, and a set beats a clear in the same cycle.
// Assumes: requests are already qualified by enable and hold.
module mbx_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic irq_n
);

    logic pending;

    // Flag state: reset clears, set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (set_req) begin
            pending <= 1'b1;
        end else if (clr_req) begin
            pending <= 1'b0;
        end
    end

    // Output drive: always driven, active low
    assign irq_n = !pending;

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> irq_n); // R1

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |=> !irq_n); // R7

    AST_CLEAR_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_req) |=> irq_n); // R4

    AST_QUIET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_req && !clr_req) |=> $stable(irq_n)); // R8

endmodule

// File: rtl/mbx_irq_flags.sv
// Module: mbx_irq_flags (top)
// Two mailbox interrupt flags for a two-sided memory. Each side's
// decoder raises the opposite flag and lowers its own; one flag
// register per side holds the state.
// Assumes: inputs are synchronous to clk; the arbiter drives hold_n.
module mbx_irq_flags
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_en_n,
    input  logic              a_wr_n,
    input  logic              a_oe_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              a_hold_n,
    input  logic              b_en_n,
    input  logic              b_wr_n,
    input  logic              b_oe_n,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              b_hold_n,
    output logic              a_irq_n,
    output logic              b_irq_n
);

    localparam int NSIDE = 2;

    side_ctl_t         ctl      [NSIDE];
    logic [ADDR_W-1:0] addr     [NSIDE];
    logic [NSIDE-1:0]  set_peer;
    logic [NSIDE-1:0]  clr_own;
    logic [NSIDE-1:0]  irq_n;

    // Gather the per-side inputs into indexed form
    always_comb begin
        ctl[0]  = '{en_n: a_en_n, wr_n: a_wr_n, oe_n: a_oe_n, hold_n: a_hold_n};
        ctl[1]  = '{en_n: b_en_n, wr_n: b_wr_n, oe_n: b_oe_n, hold_n: b_hold_n};
        addr[0] = a_addr;
        addr[1] = b_addr;
    end

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        mbx_decode #(
            .ADDR_W (ADDR_W),
            .SIDE   (side_e'(s))
        ) u_dec (
            .ctl      (ctl[s]),
            .addr     (addr[s]),
            .set_peer (set_peer[s]),
            .clr_own  (clr_own[s])
        );

        mbx_flag u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_req (set_peer[NSIDE-1-s]),
            .clr_req (clr_own[s]),
            .irq_n   (irq_n[s])
        );
    end

    assign a_irq_n = irq_n[0];
    assign b_irq_n = irq_n[1];

    AST_BOTH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_hold_n && !b_hold_n) |=> ($stable(a_irq_n) && $stable(b_irq_n))); // R6

    AST_BOTH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en_n && b_en_n) |=> ($stable(a_irq_n) && $stable(b_irq_n))); // R8

    AST_B_WRITE_RAISES_A: assert property (@(posedge clk) disable iff (!rst_n)
        (!b_en_n && !b_wr_n && b_hold_n && (b_addr == {{(ADDR_W-1){1'b1}}, 1'b0}))
        |=> !a_irq_n); // R2

    AST_A_WRITE_RAISES_B: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_en_n && !a_wr_n && a_hold_n && (a_addr == {ADDR_W{1'b1}}))
        |=> !b_irq_n); // R3

endmodule

// File: tb/sim_mbx_irq_flags.sv
// Scoreboard bench: the driver task applies one cycle of stimulus and
// queues the expected interrupt levels; the monitor pops and compares
// after the following rising edge. Instance u1 runs a 13-bit address.
module sim_mbx_irq_flags;

    localparam time HALF = 10ns; // 50 MHz

    logic        clk = 1'b0;
    logic        rst_n;
    logic        a_en_n, a_wr_n, a_oe_n, a_hold_n;
    logic        b_en_n, b_wr_n, b_oe_n, b_hold_n;
    logic [13:0] a_addr, b_addr;
    logic        a_irq_n, b_irq_n, n_a_irq_n, n_b_irq_n;

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;

    always #HALF clk = ~clk;

    mbx_irq_flags #(.ADDR_W(14)) u0 (
        .clk(clk), .rst_n(rst_n),
        .a_en_n(a_en_n), .a_wr_n(a_wr_n), .a_oe_n(a_oe_n), .a_addr(a_addr), .a_hold_n(a_hold_n),
        .b_en_n(b_en_n), .b_wr_n(b_wr_n), .b_oe_n(b_oe_n), .b_addr(b_addr), .b_hold_n(b_hold_n),
        .a_irq_n(a_irq_n), .b_irq_n(b_irq_n)
    );

    mbx_irq_flags #(.ADDR_W(13)) u1 (
        .clk(clk), .rst_n(rst_n),
        .a_en_n(a_en_n), .a_wr_n(a_wr_n), .a_oe_n(a_oe_n), .a_addr(a_addr[12:0]), .a_hold_n(a_hold_n),
        .b_en_n(b_en_n), .b_wr_n(b_wr_n), .b_oe_n(b_oe_n), .b_addr(b_addr[12:0]), .b_hold_n(b_hold_n),
        .a_irq_n(n_a_irq_n), .b_irq_n(n_b_irq_n)
    );

    // Driver: one cycle of stimulus; exp = {u0 A, u0 B, u1 A, u1 B}, 1 = deasserted
    task automatic step(input logic rst, input logic [3:0] actl, input logic [13:0] aad,
                        input logic [3:0] bctl, input logic [13:0] bad,
                        input logic [3:0] exp, input string tag);
        @(negedge clk);
        rst_n = rst;
        {a_en_n, a_wr_n, a_oe_n, a_hold_n} = actl;
        {b_en_n, b_wr_n, b_oe_n, b_hold_n} = bctl;
        a_addr = aad;
        b_addr = bad;
        q.push_back('{exp: exp, tag: tag});
    endtask

    // Monitor: compare just after the edge that consumed the stimulus
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if ({a_irq_n, b_irq_n, n_a_irq_n, n_b_irq_n} !== it.exp) begin
                fails++;
                $display("FAIL %s: got %b expected %b", it.tag,
                         {a_irq_n, b_irq_n, n_a_irq_n, n_b_irq_n}, it.exp);
            end
        end
    end

    // Control encodings {en_n, wr_n, oe_n, hold_n}
    localparam logic [3:0] IDLE = 4'b1111;
    localparam logic [3:0] WR   = 4'b0011;
    localparam logic [3:0] RD   = 4'b0101;
    localparam logic [3:0] RDWR = 4'b0001;
    localparam logic [3:0] WRH  = 4'b0010;
    localparam logic [3:0] RDH  = 4'b0100;
    localparam logic [3:0] EN   = 4'b0111;
    localparam logic [3:0] WRX  = 4'b1011;

    initial begin
        step(1'b0, IDLE, 14'h0, IDLE, 14'h0, 4'b1111, "R1 reset idle");
        step(1'b1, IDLE, 14'h0, WR, 14'h3FFE, 4'b0101, "R2 side B writes A box (R9 13-bit too)");
        step(1'b1, RDWR, 14'h3FFE, IDLE, 14'h0, 4'b1111, "R4 side A read clears, write strobe low");
        step(1'b1, WR, 14'h3FFF, IDLE, 14'h0, 4'b1010, "R3 side A writes B box");
        step(1'b1, IDLE, 14'h0, RD, 14'h3FFF, 4'b1111, "R5 side B read clears");
        step(1'b1, WRX, 14'h3FFF, WR, 14'h3FFD, 4'b1111, "R8 other address and enable high");
        step(1'b1, IDLE, 14'h0, WRH, 14'h3FFE, 4'b1111, "R6 held set ignored");
        step(1'b1, IDLE, 14'h0, WR, 14'h3FFE, 4'b0101, "R2 set again");
        step(1'b1, RDH, 14'h3FFE, IDLE, 14'h0, 4'b0101, "R6 held clear ignored");
        step(1'b1, EN, 14'h3FFE, IDLE, 14'h0, 4'b0101, "R8 enabled but no strobe");
        step(1'b1, RD, 14'h3FFE, IDLE, 14'h0, 4'b1111, "R4 clear");
        step(1'b1, RD, 14'h3FFE, WR, 14'h3FFE, 4'b0101, "R7 set wins on A flag");
        step(1'b1, WR, 14'h3FFF, RD, 14'h3FFF, 4'b0000, "R7 set wins on B flag");
        step(1'b1, RD, 14'h3FFE, RD, 14'h3FFF, 4'b1111, "R4 R5 both cleared");
        step(1'b1, IDLE, 14'h0, WR, 14'h1FFE, 4'b1101, "R9 13-bit A box only");
        step(1'b1, WR, 14'h1FFF, IDLE, 14'h0, 4'b1100, "R9 13-bit B box only");
        step(1'b1, RD, 14'h1FFE, RD, 14'h1FFF, 4'b1111, "R9 13-bit clears");
        step(1'b1, IDLE, 14'h0, IDLE, 14'h0, 4'b1111, "R8 idle keeps");
        step(1'b1, WR, 14'h3FFF, IDLE, 14'h0, 4'b1010, "R3 set before reset");
        step(1'b0, IDLE, 14'h0, WR, 14'h3FFE, 4'b1111, "R1 reset beats set");
        step(1'b1, IDLE, 14'h0, IDLE, 14'h0, 4'b1111, "R1 after reset");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule